// File: doc/BRIEF.md
# Dual-Bank Gating Command Buffer

This block sits between a link-side unpacker and a submodule valve model. The unpacker delivers gating commands as 64-bit words. Each word holds four 16-bit submodule commands. The first word of a group of eight carries submodules 8n to 8n+3, and the second carries 8n+4 to 8n+7. Each word has its own valid bit, and a shared end-of-frame bit closes the frame. The two words go into two separate banks, and each bank has its own write pointer. The buffer therefore accepts eight commands per clock when both valids arrive together, or four per clock when a protocol alternates them.

On the read side the valve model presents a slot index k and a four-bit lane mask. One clock later the buffer returns the commands of submodules 4k to 4k+3. Even slots come from the first bank and odd slots from the second. A lane whose mask bit is zero returns an all-zero command, which means every switch is off.

Each bank is double buffered. The frame being read does not change while the next frame is written. A completed frame is handed to the read side at the first calculation-cycle boundary pulse at or after its end-of-frame.

Top module: `gcb_buffer`

## Requirements
- R1: A 16-bit command passes through unchanged, reserved bits 15:8 included. Bits 3:0 are switches 1 to 4, bit 4 is the breaker, bit 5 is deactivate, bit 6 is fast discharge and bit 7 is switch 5. Lane j of a 64-bit word (bits 16j+15:16j) belongs to the j-th lowest submodule of that word.
- R2: Word 0 stores submodules 8n..8n+3 and word 1 stores 8n+4..8n+7. Slot k returns submodules 4k..4k+3: even k comes from bank 0 at address k/2, and odd k comes from bank 1 at address (k-1)/2.
- R3: Each bank's group pointer advances by one only on a clock where that bank's valid is high. A clock without that valid leaves the pointer unchanged.
- R4: When both valids are high in one clock, eight submodules are stored in that clock.
- R5: End-of-frame resets both group pointers to zero. A word written in the same clock as end-of-frame is still stored at the current pointer.
- R6: While a new frame is written, reads keep returning the previous completed frame.
- R7: A completed frame becomes readable only on the clock after the first boundary pulse at or after its end-of-frame. A read issued in the same clock as that pulse still returns the old frame. A boundary pulse with no completed frame pending changes nothing.
- R8: Read data appears on `rd_cmd` exactly one clock after the slot index and mask are presented.
- R9: A lane whose mask bit is 0 outputs 16'h0000.
- R10: After reset, `rd_cmd` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cmd0 | input | 64 | Commands of submodules 8n..8n+3 |
| wr_vld0 | input | 1 | Valid for wr_cmd0 |
| wr_cmd1 | input | 64 | Commands of submodules 8n+4..8n+7 |
| wr_vld1 | input | 1 | Valid for wr_cmd1 |
| wr_eof | input | 1 | Last write of the frame |
| cyc_last | input | 1 | Calculation-cycle boundary pulse |
| rd_slot | input | $clog2(GROUPS)+1 (4) | Read slot index |
| rd_mask | input | 4 | Active lane mask |
| rd_cmd | output | 64 | Four submodule commands, one clock after the slot |

## Verification
The assertions assume that the unpacker sends no command word between an end-of-frame and the boundary pulse that hands the frame over, and that no frame holds more than GROUPS words per bank. The bench keeps within both. Every frame it writes has at most eight groups per bank, and it raises the boundary pulse before the next frame's first word. It writes frames with paired valids, with alternating single valids and idle gaps, and with end-of-frame both on a data word and on its own. While doing so it reads back with varied masks, including reads in the clocks around the hand-over.

// File: rtl/gcb_pkg.sv
package gcb_pkg;
  localparam int CMD_W  = 16;
  localparam int LANES  = 4;
  localparam int WORD_W = CMD_W * LANES;

  // Zero every lane whose mask bit is clear (switches off).
  function automatic logic [WORD_W-1:0] lane_gate(input logic [WORD_W-1:0] w,
                                                  input logic [LANES-1:0]  m);
    logic [WORD_W-1:0] r;
    for (int j = 0; j < LANES; j++)
      r[j*CMD_W +: CMD_W] = m[j] ? w[j*CMD_W +: CMD_W] : '0;
    return r;
  endfunction

  // Slot k -> bank (k mod 2), address (k div 2).
  function automatic logic slot_bank(input logic [15:0] k);
    return k[0];
  endfunction
endpackage

// File: rtl/gcb_wr_ptr.sv
module gcb_wr_ptr #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic          eof,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr_q <= '0;
    else if (eof)  ptr_q <= '0;
    else if (vld)  ptr_q <= ptr_q + 1'b1;
  end

  assign ptr = ptr_q;

  p_ptr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> ptr == '0);
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !eof) |=> ptr == AW'($past(ptr) + 1'b1));
  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld && !eof) |=> $stable(ptr));
endmodule

// File: rtl/gcb_bank.sv
module gcb_bank #(
  parameter int AW = 3,
  parameter int W  = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wpage,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rpage,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 2 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{wpage, waddr}] <= wdata;
  end

  assign rdata = mem[{rpage, raddr}];
endmodule

// File: rtl/gcb_page_ctl.sv
module gcb_page_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic eof,
  input  logic cyc_last,
  input  logic wr_any,
  output logic wr_page,
  output logic rd_page,
  output logic pending
);
  logic page_q, pend_q, swap;

  assign swap = cyc_last & (pend_q | eof);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (swap) page_q <= ~page_q;
      pend_q <= swap ? 1'b0 : (pend_q | eof);
    end
  end

  assign wr_page = page_q;
  assign rd_page = ~page_q;
  assign pending = pend_q;

  p_boundary_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_last |=> $stable(rd_page));
  p_pending_swaps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && cyc_last) |=> rd_page != $past(rd_page));
  p_no_write_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !wr_any);
endmodule

// File: rtl/gcb_buffer.sv
module gcb_buffer
  import gcb_pkg::*;
#(
  parameter int GROUPS = 8,
  localparam int AW     = $clog2(GROUPS),
  localparam int SLOT_W = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] wr_cmd0,
  input  logic              wr_vld0,
  input  logic [WORD_W-1:0] wr_cmd1,
  input  logic              wr_vld1,
  input  logic              wr_eof,
  input  logic              cyc_last,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [LANES-1:0]  rd_mask,
  output logic [WORD_W-1:0] rd_cmd
);
  logic              wr_page, rd_page, pending;
  logic              vld   [2];
  logic [WORD_W-1:0] wdat  [2];
  logic [AW-1:0]     ptr   [2];
  logic [WORD_W-1:0] rdat  [2];
  logic [AW-1:0]     raddr;
  logic              rbank;
  logic [WORD_W-1:0] cmd_q;

  assign vld[0]  = wr_vld0;
  assign vld[1]  = wr_vld1;
  assign wdat[0] = wr_cmd0;
  assign wdat[1] = wr_cmd1;
  assign raddr   = rd_slot[SLOT_W-1:1];
  assign rbank   = slot_bank(16'(rd_slot));

  gcb_page_ctl u_page (
    .clk(clk), .rst_n(rst_n), .eof(wr_eof), .cyc_last(cyc_last),
    .wr_any(wr_vld0 | wr_vld1), .wr_page(wr_page), .rd_page(rd_page),
    .pending(pending)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    gcb_wr_ptr #(.AW(AW)) u_ptr (
      .clk(clk), .rst_n(rst_n), .vld(vld[b]), .eof(wr_eof), .ptr(ptr[b])
    );
    gcb_bank #(.AW(AW), .W(WORD_W)) u_ram (
      .clk(clk), .we(vld[b]), .wpage(wr_page), .waddr(ptr[b]),
      .wdata(wdat[b]), .rpage(rd_page), .raddr(raddr), .rdata(rdat[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= lane_gate(rdat[rbank], rd_mask);
  end

  assign rd_cmd = cmd_q;

  for (genvar j = 0; j < LANES; j++) begin : g_lane_chk
    p_lane_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_mask[j] |=> rd_cmd[j*CMD_W +: CMD_W] == '0);
  end
endmodule

// File: tb/test_gcb_buffer.sv
module test_gcb_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] wr_cmd0 = '0, wr_cmd1 = '0;
  logic        wr_vld0 = 1'b0, wr_vld1 = 1'b0, wr_eof = 1'b0, cyc_last = 1'b0;
  logic [3:0]  rd_slot = '0;
  logic [3:0]  rd_mask = 4'hF;
  logic [63:0] rd_cmd;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int          due_q[$];
  logic [63:0] exp_q[$];
  string       tag_q[$];

  gcb_buffer #(.GROUPS(8)) i_gcb_buffer (
    .clk(clk), .rst_n(rst_n), .wr_cmd0(wr_cmd0), .wr_vld0(wr_vld0),
    .wr_cmd1(wr_cmd1), .wr_vld1(wr_vld1), .wr_eof(wr_eof),
    .cyc_last(cyc_last), .rd_slot(rd_slot), .rd_mask(rd_mask), .rd_cmd(rd_cmd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Unique command per (frame, submodule); reserved bits nonzero (R1).
  function automatic logic [15:0] cmdv(input int f, input int s);
    return {4'(f), 4'hA, 8'(s * 3 + 1)};
  endfunction

  function automatic logic [63:0] word_of(input int f, input int first_sub);
    logic [63:0] w;
    for (int j = 0; j < 4; j++) w[j*16 +: 16] = cmdv(f, first_sub + j);
    return w;
  endfunction

  function automatic logic [63:0] exp_slot(input int f, input int k, input logic [3:0] m);
    logic [63:0] w;
    w = word_of(f, 4 * k);
    for (int j = 0; j < 4; j++) if (!m[j]) w[j*16 +: 16] = 16'h0000;
    return w;
  endfunction

  // Drivers: set inputs for the coming edge (called right after a negedge).
  task automatic set_wr(input logic v0, input logic v1, input int f, input int g,
                        input logic eof);
    wr_vld0 = v0; wr_vld1 = v1; wr_eof = eof;
    wr_cmd0 = word_of(f, 8 * g);
    wr_cmd1 = word_of(f, 8 * g + 4);
  endtask

  task automatic set_rd(input int f, input int k, input logic [3:0] m, input string tag);
    rd_slot = 4'(k); rd_mask = m;
    due_q.push_back(cyc + 1);
    exp_q.push_back(exp_slot(f, k, m));
    tag_q.push_back(tag);
  endtask

  task automatic idle_wr();
    wr_vld0 = 1'b0; wr_vld1 = 1'b0; wr_eof = 1'b0; cyc_last = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    idle_wr();
  endtask

  // Monitor: compares the result one clock after each read (R8).
  always @(negedge clk) begin
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      logic [63:0] e;
      string t;
      void'(due_q.pop_front());
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (rd_cmd !== e) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", t, rd_cmd, e);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    n_cmp++;
    if (rd_cmd !== 64'h0) begin
      n_bad++;
      $display("FAIL R10: got %h expected %h", rd_cmd, 64'h0);
    end

    // Frame 1: paired valids, eight per clock (R4), eof on last word (R5)
    for (int g = 0; g < 8; g++) begin
      set_wr(1'b1, 1'b1, 1, g, g == 7);
      step();
    end
    cyc_last = 1'b1; @(negedge clk); idle_wr();
    for (int k = 0; k < 16; k++) begin
      set_rd(1, k, 4'hF, "R2 R4 slot map frame1");
      step();
    end

    // Frame 2: alternating single valids with idle gaps (R3) while frame 1 is read (R6)
    for (int g = 0; g < 8; g++) begin
      set_wr(1'b1, 1'b0, 2, g, 1'b0);
      set_rd(1, (2 * g) % 16, 4'hF, "R6 old frame during write");
      step();
      set_rd(1, (2 * g + 1) % 16, 4'hF, "R6 old frame during idle");
      step();
      set_wr(1'b0, 1'b1, 2, g, g == 7);
      set_rd(1, 15 - g, 4'hF, "R6 old frame during write");
      step();
    end
    // R7: eof done, no boundary yet -> still frame 1
    set_rd(1, 3, 4'hF, "R7 before boundary");
    step();
    set_rd(1, 4, 4'hF, "R7 read on boundary clock");
    cyc_last = 1'b1; @(negedge clk); idle_wr();
    for (int k = 0; k < 16; k++) begin
      set_rd(2, k, 4'hF, "R3 R7 frame2 after boundary");
      step();
    end

    // Frame 3: two groups, then masks (R9, R1)
    set_wr(1'b1, 1'b1, 3, 0, 1'b0); step();
    set_wr(1'b1, 1'b1, 3, 1, 1'b1); step();
    cyc_last = 1'b1; @(negedge clk); idle_wr();
    set_rd(3, 0, 4'b0101, "R9 mask 0101"); step();
    set_rd(3, 1, 4'b1010, "R9 mask 1010"); step();
    set_rd(3, 2, 4'b0000, "R9 mask 0000"); step();
    set_rd(3, 3, 4'b1000, "R9 R1 lane 3 only"); step();
    set_rd(3, 2, 4'hF,    "R1 R2 full word"); step();

    // Frame 4: eof on its own clock (R5)
    set_wr(1'b1, 1'b1, 4, 0, 1'b0); step();
    wr_eof = 1'b1; step();
    cyc_last = 1'b1; @(negedge clk); idle_wr();
    set_rd(4, 0, 4'hF, "R5 eof alone frame4"); step();
    set_rd(4, 1, 4'hF, "R5 eof alone frame4"); step();

    // Frame 5: pointers were cleared, lands at address 0 (R5)
    set_wr(1'b1, 1'b1, 5, 0, 1'b1); step();
    cyc_last = 1'b1; @(negedge clk); idle_wr();
    set_rd(5, 0, 4'hF, "R5 pointer reset"); step();
    set_rd(5, 1, 4'hF, "R5 pointer reset"); step();

    // Boundary with nothing pending: no swap (R7)
    cyc_last = 1'b1; @(negedge clk); idle_wr();
    set_rd(5, 0, 4'hF, "R7 idle boundary"); step();
    set_rd(5, 1, 4'hE, "R7 R9 idle boundary"); step();

    repeat (3) step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule